// File: doc/BRIEF.md
# GPIO Pad Drive and Pull Resolver

This block settles, for every pad of a parallel I/O port, what actually happens on the pin each clock cycle. It takes the per-pin configuration fields from a separate register block, the software output bit, and an external stimulus per pin (a valid flag plus a level). From these it works out whether the output driver is connected and which level the pad carries. It also decides what the input sample register holds and whether the pin is short-circuited.

Pulls act on a floating pad. When nothing else drives the pin and its input buffer is connected, the pull level goes out on the pad and is also sampled back as the input. Two drive modes connect the driver for only one output level, in the open-drain and open-source style. Each pin raises a one-cycle change strobe whenever its pad connection or pad level moves. A sticky short-circuit flag records contention, and a write-one-to-clear vector clears it.

Top module: `gpio_pad_resolver`

## Requirements
- R1: The 3-bit drive mode of a pin (configuration bits [10:8]) connects the driver for codes 0 to 3 always, for codes 4 and 5 only while the output bit is 1, and for codes 6 and 7 only while the output bit is 0.
- R2: The driver is connected only when the drive-mode condition holds and the pin's direction bit (configuration bit 0) is 1. Otherwise the pad shows high impedance (pad_oe 0), unless a pull substitutes per R5.
- R3: The 2-bit pull field (configuration bits [3:2]) gives pull-down for code 1 and pull-up for code 3. Codes 0 and 2 mean no pull.
- R4: While the input buffer is disconnected (configuration bit 1 = 1) and a pull is active, the pin's input bit equals the pull level, whatever the external stimulus. With no pull, the external level is taken when valid, and the input bit holds otherwise.
- R5: With the input buffer connected, no valid external stimulus, an active pull and the driver not connected, the pad is driven to the pull level: pad_oe is 1, and both pad_lvl and the input bit equal the pull level.
- R6: With the input buffer connected, no valid external stimulus and the driver connected, the input bit takes the output bit. Whenever no pull substitutes, pad_lvl equals the output bit, including when the driver is disconnected.
- R7: A valid external stimulus puts its level on the input bit. If the input buffer is connected, the driver is connected and the output bit differs from the external level, the pin's short-circuit flag is raised.
- R8: A pin that is not externally driven, has no connected driver and no active pull keeps its last input bit. Releasing the external stimulus therefore leaves the last sampled level in place.
- R9: All results are registered and appear one clock after their inputs. pad_chg for a pin is a one-cycle pulse, issued with the new values, whenever that pin's pad_oe or pad_lvl differs from the previous cycle.
- R10: Short-circuit flags are sticky per pin. A 1 in sc_clr clears the flag on the next clock. A new short in the same cycle wins over the clear.
- R11: After reset, in_bits, pad_oe, pad_lvl, pad_chg and short_flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_dir | input | NPIN | Direction bit per pin (configuration bit 0) |
| pin_ibuf_off | input | NPIN | Input buffer disconnect per pin (configuration bit 1) |
| pin_pull | input | 2*NPIN | Pull code per pin, pin i at [2i+1:2i] |
| pin_mode | input | 3*NPIN | Drive mode per pin, pin i at [3i+2:3i] |
| out_bits | input | NPIN | Software output bit per pin |
| ext_valid | input | NPIN | External stimulus valid per pin |
| ext_level | input | NPIN | External stimulus level per pin |
| sc_clr | input | NPIN | Write-one-to-clear for short-circuit flags |
| in_bits | output | NPIN | Resolved input sample per pin |
| pad_oe | output | NPIN | Pad driven (1) or high impedance (0) |
| pad_lvl | output | NPIN | Pad level |
| pad_chg | output | NPIN | One-cycle pad change strobe |
| short_flag | output | NPIN | Sticky short-circuit flag |

## Verification
Every output is one register stage behind its inputs. The bench drives a stimulus at a falling edge, lets exactly one rising edge pass, and samples in_bits, pad_oe, pad_lvl, pad_chg and short_flag at the following falling edge. The change strobe belongs to the same edge as the new pad values, so the expected strobe is computed from the reference pad state before and after that one edge. A repeated stimulus is then checked to give a zero strobe. Input hold and flag stickiness span several steps, and the reference model carries that state from step to step.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int MODE_W = 3;
  localparam int PULL_W = 2;

  localparam logic [PULL_W-1:0] PULL_DN = 2'd1;
  localparam logic [PULL_W-1:0] PULL_UP = 2'd3;

  // Drive mode condition: always, only on high, only on low
  function automatic logic drive_allowed(input logic [MODE_W-1:0] mode, input logic o);
    logic ok;
    case (mode)
      3'd0, 3'd1, 3'd2, 3'd3: ok = 1'b1;
      3'd4, 3'd5:             ok = o;
      default:                ok = !o;
    endcase
    return ok;
  endfunction

  function automatic logic pull_active(input logic [PULL_W-1:0] p);
    return (p == PULL_DN) || (p == PULL_UP);
  endfunction

  function automatic logic pull_level(input logic [PULL_W-1:0] p);
    return (p == PULL_UP);
  endfunction

  typedef struct packed {
    logic conn_raw;
    logic pull_sub;
    logic force_in;
    logic force_val;
    logic oe;
    logic lvl;
    logic in_nx;
    logic short_now;
  } pin_res_t;
endpackage

// File: rtl/gpr_pin_eval.sv
module gpr_pin_eval
  import gpr_pkg::*;
(
  input  logic              dir,
  input  logic              ibuf_off,
  input  logic [PULL_W-1:0] pull,
  input  logic [MODE_W-1:0] mode,
  input  logic              out_bit,
  input  logic              ext_vld,
  input  logic              ext_lvl,
  input  logic              in_cur,
  output pin_res_t          res
);
  logic pon;

  always_comb begin
    pon           = pull_active(pull);
    res.conn_raw  = dir & drive_allowed(mode, out_bit);
    res.force_val = pull_level(pull);
    res.force_in  = ibuf_off & pon;
    res.pull_sub  = !ibuf_off & !ext_vld & pon & !res.conn_raw;
    res.oe        = res.conn_raw | res.pull_sub;
    res.lvl       = res.pull_sub ? res.force_val : out_bit;
    res.short_now = !ibuf_off & ext_vld & res.conn_raw & (out_bit != ext_lvl);
    if (res.force_in)
      res.in_nx = res.force_val;
    else if (ext_vld)
      res.in_nx = ext_lvl;
    else if (!ibuf_off && res.oe)
      res.in_nx = res.lvl;
    else
      res.in_nx = in_cur;
  end
endmodule

// File: rtl/gpr_pin_regs.sv
module gpr_pin_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic in_nx,
  input  logic oe_nx,
  input  logic lvl_nx,
  input  logic short_now,
  input  logic clr,
  output logic in_q,
  output logic oe_q,
  output logic lvl_q,
  output logic chg_q,
  output logic short_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q    <= 1'b0;
      oe_q    <= 1'b0;
      lvl_q   <= 1'b0;
      chg_q   <= 1'b0;
      short_q <= 1'b0;
    end else begin
      in_q    <= in_nx;
      oe_q    <= oe_nx;
      lvl_q   <= lvl_nx;
      chg_q   <= (oe_nx ^ oe_q) | (lvl_nx ^ lvl_q);
      short_q <= short_now | (short_q & ~clr);
    end
  end
endmodule

// File: rtl/gpio_pad_resolver.sv
module gpio_pad_resolver
  import gpr_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPIN-1:0]        pin_dir,
  input  logic [NPIN-1:0]        pin_ibuf_off,
  input  logic [PULL_W*NPIN-1:0] pin_pull,
  input  logic [MODE_W*NPIN-1:0] pin_mode,
  input  logic [NPIN-1:0]        out_bits,
  input  logic [NPIN-1:0]        ext_valid,
  input  logic [NPIN-1:0]        ext_level,
  input  logic [NPIN-1:0]        sc_clr,
  output logic [NPIN-1:0]        in_bits,
  output logic [NPIN-1:0]        pad_oe,
  output logic [NPIN-1:0]        pad_lvl,
  output logic [NPIN-1:0]        pad_chg,
  output logic [NPIN-1:0]        short_flag
);
  // Named internal events for the checker
  logic [NPIN-1:0] conn_raw;
  logic [NPIN-1:0] pull_sub;
  logic [NPIN-1:0] ev_short;
  logic [NPIN-1:0] force_in;
  logic [NPIN-1:0] force_val;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    pin_res_t res;

    gpr_pin_eval u_eval (
      .dir      (pin_dir[i]),
      .ibuf_off (pin_ibuf_off[i]),
      .pull     (pin_pull[PULL_W*i +: PULL_W]),
      .mode     (pin_mode[MODE_W*i +: MODE_W]),
      .out_bit  (out_bits[i]),
      .ext_vld  (ext_valid[i]),
      .ext_lvl  (ext_level[i]),
      .in_cur   (in_bits[i]),
      .res      (res)
    );

    gpr_pin_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_nx     (res.in_nx),
      .oe_nx     (res.oe),
      .lvl_nx    (res.lvl),
      .short_now (res.short_now),
      .clr       (sc_clr[i]),
      .in_q      (in_bits[i]),
      .oe_q      (pad_oe[i]),
      .lvl_q     (pad_lvl[i]),
      .chg_q     (pad_chg[i]),
      .short_q   (short_flag[i])
    );

    assign conn_raw[i]  = res.conn_raw;
    assign pull_sub[i]  = res.pull_sub;
    assign ev_short[i]  = res.short_now;
    assign force_in[i]  = res.force_in;
    assign force_val[i] = res.force_val;
  end
endmodule

// File: rtl/gpr_checker.sv
module gpr_checker #(
  parameter int NPIN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NPIN-1:0] sc_clr,
  input logic [NPIN-1:0] in_bits,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] pad_lvl,
  input logic [NPIN-1:0] pad_chg,
  input logic [NPIN-1:0] short_flag,
  input logic [NPIN-1:0] conn_raw,
  input logic [NPIN-1:0] pull_sub,
  input logic [NPIN-1:0] ev_short,
  input logic [NPIN-1:0] force_in,
  input logic [NPIN-1:0] force_val
);
  // R2: a driven pad needs a connected driver or a pull substitution
  a_r2_oe_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~$past(conn_raw | pull_sub)) == '0);

  // R4: disconnected input buffer with pull pins the input bit
  a_r4_forced_input: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(force_in) & (in_bits ^ $past(force_val))) == '0);

  // R7: a newly raised short flag needs a contention event
  a_r7_short_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (short_flag & ~$past(short_flag) & ~$past(ev_short)) == '0);

  // R9: strobe marks exactly the pins whose pad state moved
  a_r9_chg_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    pad_chg == ((pad_oe ^ $past(pad_oe)) | (pad_lvl ^ $past(pad_lvl))));

  // R10: a flag only drops when cleared
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(short_flag) & ~$past(sc_clr) & ~short_flag) == '0);
endmodule

bind gpio_pad_resolver gpr_checker #(.NPIN(NPIN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sc_clr     (sc_clr),
  .in_bits    (in_bits),
  .pad_oe     (pad_oe),
  .pad_lvl    (pad_lvl),
  .pad_chg    (pad_chg),
  .short_flag (short_flag),
  .conn_raw   (conn_raw),
  .pull_sub   (pull_sub),
  .ev_short   (ev_short),
  .force_in   (force_in),
  .force_val  (force_val)
);

// File: tb/gpio_pad_resolver_test.sv
module gpio_pad_resolver_test;
  localparam int N = 32;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]   pin_dir = '0, pin_ibuf_off = '0, out_bits = '0;
  logic [N-1:0]   ext_valid = '0, ext_level = '0, sc_clr = '0;
  logic [2*N-1:0] pin_pull = '0;
  logic [3*N-1:0] pin_mode = '0;
  logic [N-1:0]   in_bits, pad_oe, pad_lvl, pad_chg, short_flag;

  logic [N-1:0] m_in = '0, m_oe = '0, m_lvl = '0, m_short = '0;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pad_resolver #(.NPIN(N)) uut (
    .clk(clk), .rst_n(rst_n), .pin_dir(pin_dir), .pin_ibuf_off(pin_ibuf_off),
    .pin_pull(pin_pull), .pin_mode(pin_mode), .out_bits(out_bits),
    .ext_valid(ext_valid), .ext_level(ext_level), .sc_clr(sc_clr),
    .in_bits(in_bits), .pad_oe(pad_oe), .pad_lvl(pad_lvl), .pad_chg(pad_chg),
    .short_flag(short_flag)
  );

  // Reference per pin: returns {short, in, lvl, oe}
  function automatic logic [3:0] ref_pin(input logic [2:0] md, input logic [1:0] pl,
      input logic ibo, input logic d, input logic o, input logic ev, input logic el,
      input logic ip);
    logic on, pe, pv, oe, lv, inn, sc;
    case (md[2:1])
      2'b10:   on = o;
      2'b11:   on = !o;
      default: on = 1'b1;
    endcase
    on = on & d;
    pe = (pl == 2'd1) || (pl == 2'd3);
    pv = (pl == 2'd3);
    oe = on; lv = o; inn = ip; sc = 1'b0;
    if (ibo) begin
      if (ev) inn = el;
      if (pe) inn = pv;
    end else if (ev) begin
      inn = el;
      sc = on & (o != el);
    end else if (on) begin
      inn = o;
    end else if (pe) begin
      oe = 1'b1; lv = pv; inn = pv;
    end
    return {sc, inn, lv, oe};
  endfunction

  task automatic vcheck(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bcheck(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Apply current inputs for one edge and compare against the model
  task automatic step();
    logic [N-1:0] n_in, n_oe, n_lvl, n_sc, e_chg;
    for (int i = 0; i < N; i++) begin
      logic [3:0] r;
      r = ref_pin(pin_mode[3*i +: 3], pin_pull[2*i +: 2], pin_ibuf_off[i], pin_dir[i],
                  out_bits[i], ext_valid[i], ext_level[i], m_in[i]);
      {n_sc[i], n_in[i], n_lvl[i], n_oe[i]} = r;
    end
    e_chg   = (n_oe ^ m_oe) | (n_lvl ^ m_lvl);
    m_short = n_sc | (m_short & ~sc_clr);
    m_in = n_in; m_oe = n_oe; m_lvl = n_lvl;
    @(posedge clk);
    @(negedge clk);
    vcheck("R4 R5 R6 R7 R8 in_bits", in_bits, m_in);
    vcheck("R1 R2 R5 pad_oe", pad_oe, m_oe);
    vcheck("R5 R6 pad_lvl", pad_lvl, m_lvl);
    vcheck("R9 pad_chg", pad_chg, e_chg);
    vcheck("R7 R10 short_flag", short_flag, m_short);
  endtask

  task automatic pin0(input logic [2:0] md, input logic [1:0] pl, input logic ibo,
      input logic d, input logic o, input logic ev, input logic el, input logic clr);
    pin_mode[2:0] = md; pin_pull[1:0] = pl; pin_ibuf_off[0] = ibo; pin_dir[0] = d;
    out_bits[0] = o; ext_valid[0] = ev; ext_level[0] = el; sc_clr[0] = clr;
    step();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state
    vcheck("R11 in_bits", in_bits, '0);
    vcheck("R11 pad_oe", pad_oe, '0);
    vcheck("R11 pad_lvl", pad_lvl, '0);
    vcheck("R11 pad_chg", pad_chg, '0);
    vcheck("R11 short_flag", short_flag, '0);

    pin0(3'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    bcheck("R1 push-pull oe", pad_oe[0], 1'b1);
    bcheck("R6 in follows out", in_bits[0], 1'b1);
    bcheck("R9 strobe on change", pad_chg[0], 1'b1);
    pin0(3'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    bcheck("R9 no strobe when steady", pad_chg[0], 1'b0);
    pin0(3'd4, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    bcheck("R1 mode4 low off", pad_oe[0], 1'b0);
    bcheck("R8 in holds", in_bits[0], 1'b1);
    pin0(3'd5, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    bcheck("R1 mode5 high on", pad_oe[0], 1'b1);
    pin0(3'd6, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    bcheck("R1 mode6 high off", pad_oe[0], 1'b0);
    pin0(3'd7, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    bcheck("R1 mode7 low on", pad_oe[0], 1'b1);
    pin0(3'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    bcheck("R2 dir off", pad_oe[0], 1'b0);
    pin0(3'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    bcheck("R5 pull-up oe", pad_oe[0], 1'b1);
    bcheck("R3 R5 pull-up lvl", pad_lvl[0], 1'b1);
    bcheck("R5 pull-up in", in_bits[0], 1'b1);
    pin0(3'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    bcheck("R3 R5 pull-down in", in_bits[0], 1'b0);
    pin0(3'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    bcheck("R3 code2 no pull", pad_oe[0], 1'b0);
    pin0(3'd0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    bcheck("R4 ibuf off pull wins", in_bits[0], 1'b1);
    pin0(3'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    bcheck("R7 ext level", in_bits[0], 1'b1);
    bcheck("R7 short raised", short_flag[0], 1'b1);
    pin0(3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    bcheck("R8 release holds", in_bits[0], 1'b1);
    bcheck("R10 flag sticky", short_flag[0], 1'b1);
    pin0(3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    bcheck("R10 clear", short_flag[0], 1'b0);
    pin0(3'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    bcheck("R10 set beats clear", short_flag[0], 1'b1);

    // Random mix over all pins
    for (int k = 0; k < 400; k++) begin
      pin_dir      = $urandom();
      pin_ibuf_off = $urandom() & $urandom();
      out_bits     = $urandom();
      ext_valid    = $urandom() & $urandom();
      ext_level    = $urandom();
      sc_clr       = $urandom() & $urandom() & $urandom();
      pin_pull     = {$urandom(), $urandom()};
      pin_mode     = {$urandom(), $urandom(), $urandom()};
      step();
      if (k % 7 == 0) step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule